// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits next to an ECC-protected on-chip RAM and keeps a history of failing reads. Each time the read path reports a correctable or uncorrectable error, the block stores the word address and the error kind as one entry in a first-in, first-out log. Software reads the oldest entry through a small 32-bit register bus. It then removes that entry with a self-clearing pop bit. It can also watch the fill level and a sticky overflow flag.

Software can start a soft reset that lasts a fixed number of cycles. The soft reset empties the log, clears the overflow flag and clears the parity register. The block also drives two outputs for the write path of the RAM: an encoder-bypass enable, and an 8-bit parity value that the RAM uses in place of the encoder output while bypass is on.

The error input is a valid-qualified event stream with no ready signal. The log cannot apply back-pressure to the read path. An event that finds the log full is dropped, and the block records the loss in the overflow flag. A register read returns its data on `reg_rdata` one cycle after `reg_rd`. `reg_rdata` holds that value until the next read.

Top module: `ecc_err_log`

## Requirements
- R1: An event with `evt_valid` high and at least one of `evt_corr`/`evt_unc` set appends one entry, and entries leave in arrival order. An event with both flags low is ignored. The oldest address reads at offset 0x4 in bits [ADDR_W-1:0]. The oldest status reads at offset 0x8, with the correctable flag in bit 0 and the uncorrectable flag in bit 16.
- R2: Offset 0x0 bits [LVL_W-1:0] give the entry count modulo DEPTH, where LVL_W = log2(DEPTH). A log holding all DEPTH entries therefore reads as 0.
- R3: An event that arrives while DEPTH entries are held, with no pop in the same cycle, is dropped. It sets the sticky flag at offset 0x0 bit 31. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R4: Writing 1 to offset 0xC bit 1 requests a pop. The bit reads 1 for one cycle. One entry is then removed from the log, and the bit returns to 0 by itself.
- R5: A pop request on an empty log changes nothing, and its bit still clears. A pop and an accepted event in the same cycle leave the count unchanged.
- R6: Reading offset 0x4 or 0x8 while the log is empty returns 0.
- R7: Writing 1 to offset 0xC bit 0 starts a soft reset. The bit reads 1 for exactly SRST_CYCLES cycles (8 by default). During that time the log is emptied, the overflow flag and the parity register are cleared, and events and parity writes are ignored. Writing bit 0 again while the soft reset runs does not lengthen it.
- R8: Offset 0xC bit 2 is written into the `bypass_en` output. Offset 0x10 bits [7:0] hold the parity value driven on `parity_out`.
- R9: Read data appears on `reg_rdata` one cycle after the `reg_rd` strobe. Reserved bits and unmapped offsets read 0. Every register is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Error event present this cycle |
| evt_addr | input | ADDR_W | Word address of the failing read |
| evt_corr | input | 1 | Event is a correctable error |
| evt_unc | input | 1 | Event is an uncorrectable error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after `reg_rd` |
| bypass_en | output | 1 | Encoder-bypass enable for the RAM write path |
| parity_out | output | 8 | Parity value used while bypass is on |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume that `reg_addr` is one of the word-aligned offsets whenever a strobe is high. The overflow and pop properties treat every event with a flag set as a push attempt, whatever the address.

The stimulus drives a single strobe or event per cycle, with one exception: a pop request deliberately coincides with an event to exercise the simultaneous case. The bench drives inputs only at the falling edge and holds them low otherwise, so no property sees a glitch on a strobe.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam logic [4:0] OFF_LEVEL = 5'h00;
  localparam logic [4:0] OFF_ADDR  = 5'h04;
  localparam logic [4:0] OFF_STAT  = 5'h08;
  localparam logic [4:0] OFF_CTRL  = 5'h0C;
  localparam logic [4:0] OFF_PAR   = 5'h10;

  localparam int CTRL_SRST = 0;
  localparam int CTRL_POP  = 1;
  localparam int CTRL_BYP  = 2;
  localparam int LVL_OVF   = 31;
  localparam int STAT_CORR = 0;
  localparam int STAT_UNC  = 16;
  localparam int PAR_W     = 8;

  typedef struct packed {
    logic unc;
    logic corr;
  } err_kind_t;
endpackage

// File: rtl/ecc_log_fifo.sv
module ecc_log_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 28
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        push,
  input  logic                        pop,
  input  logic [W-1:0]                din,
  output logic [W-1:0]                head,
  output logic [$clog2(DEPTH):0]      count,
  output logic                        empty,
  output logic                        full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty && !clr;
  assign do_push = push && !clr && (!full || do_pop);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ecc_log_srst.sv
module ecc_log_srst #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == CNT_W'(CYCLES - 1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end
  end
endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int LVL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              srst_active,
  input  logic              drop,
  input  logic [LVL_W-1:0]  level,
  input  logic              empty,
  input  logic [ADDR_W-1:0] head_addr,
  input  err_kind_t         head_kind,
  output logic [31:0]       reg_rdata,
  output logic              srst_start,
  output logic              pop_pend,
  output logic              ovf_flag,
  output logic              bypass_en,
  output logic [PAR_W-1:0]  parity_out
);
  logic        wr_lvl, wr_ctrl, wr_par;
  logic [31:0] rd_mux;
  logic        unused_wdata;

  assign wr_lvl       = reg_wr && (reg_addr == OFF_LEVEL);
  assign wr_ctrl      = reg_wr && (reg_addr == OFF_CTRL);
  assign wr_par       = reg_wr && (reg_addr == OFF_PAR);
  assign srst_start   = wr_ctrl && reg_wdata[CTRL_SRST] && !srst_active;
  assign unused_wdata = ^reg_wdata[30:PAR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag   <= 1'b0;
      pop_pend   <= 1'b0;
      bypass_en  <= 1'b0;
      parity_out <= '0;
    end else begin
      pop_pend <= wr_ctrl && reg_wdata[CTRL_POP];
      if (wr_ctrl) bypass_en <= reg_wdata[CTRL_BYP];
      if (srst_active)                      ovf_flag <= 1'b0;
      else if (drop)                        ovf_flag <= 1'b1;
      else if (wr_lvl && reg_wdata[LVL_OVF]) ovf_flag <= 1'b0;
      if (srst_active)  parity_out <= '0;
      else if (wr_par)  parity_out <= reg_wdata[PAR_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFF_LEVEL: begin
        rd_mux          = 32'(level);
        rd_mux[LVL_OVF] = ovf_flag;
      end
      OFF_ADDR: if (!empty) rd_mux = 32'(head_addr);
      OFF_STAT: if (!empty) begin
        rd_mux[STAT_CORR] = head_kind.corr;
        rd_mux[STAT_UNC]  = head_kind.unc;
      end
      OFF_CTRL: begin
        rd_mux[CTRL_SRST] = srst_active;
        rd_mux[CTRL_POP]  = pop_pend;
        rd_mux[CTRL_BYP]  = bypass_en;
      end
      OFF_PAR:  rd_mux = 32'(parity_out);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int DEPTH       = 512,
  parameter int SRST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_corr,
  input  logic              evt_unc,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              bypass_en,
  output logic [7:0]        parity_out
);
  localparam int LVL_W   = $clog2(DEPTH);
  localparam int ENTRY_W = ADDR_W + $bits(err_kind_t);

  logic              srst_active, srst_start;
  logic              pop_pend, ovf_flag;
  logic              evt_hit, drop;
  logic              fifo_empty, fifo_full;
  logic [LVL_W:0]    fifo_count;
  logic [ENTRY_W-1:0] fifo_din, fifo_head;
  err_kind_t         evt_kind, head_kind;
  logic [ADDR_W-1:0] head_addr;
  logic              unused_cnt;

  assign evt_kind.corr = evt_corr;
  assign evt_kind.unc  = evt_unc;
  assign evt_hit  = evt_valid && (evt_corr || evt_unc) && !srst_active;
  assign drop     = evt_hit && fifo_full && !pop_pend;
  assign fifo_din = {evt_kind, evt_addr};
  assign {head_kind, head_addr} = fifo_head;
  assign unused_cnt = fifo_count[LVL_W];

  ecc_log_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (srst_active),
    .push  (evt_hit),
    .pop   (pop_pend),
    .din   (fifo_din),
    .head  (fifo_head),
    .count (fifo_count),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  ecc_log_srst #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (srst_start),
    .active (srst_active)
  );

  ecc_log_regs #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .srst_active (srst_active),
    .drop        (drop),
    .level       (fifo_count[LVL_W-1:0]),
    .empty       (fifo_empty),
    .head_addr   (head_addr),
    .head_kind   (head_kind),
    .reg_rdata   (reg_rdata),
    .srst_start  (srst_start),
    .pop_pend    (pop_pend),
    .ovf_flag    (ovf_flag),
    .bypass_en   (bypass_en),
    .parity_out  (parity_out)
  );
endmodule

// File: rtl/ecc_log_chk.sv
module ecc_log_chk
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int DEPTH       = 512,
  parameter int SRST_CYCLES = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     evt_valid,
  input logic                     evt_corr,
  input logic                     evt_unc,
  input logic                     reg_wr,
  input logic                     reg_rd,
  input logic [4:0]               reg_addr,
  input logic [31:0]              reg_wdata,
  input logic [31:0]              reg_rdata,
  input logic [7:0]               parity_out,
  input logic                     srst_active,
  input logic                     pop_pend,
  input logic                     ovf_flag,
  input logic                     fifo_empty,
  input logic [$clog2(DEPTH):0]   fifo_count
);
  logic [15:0] run_len;
  logic        evt_any;

  assign evt_any = evt_valid && (evt_corr || evt_unc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_len <= '0;
    else if (srst_active) run_len <= run_len + 1'b1;
    else                  run_len <= '0;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH)+1)'(DEPTH)); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_any && !srst_active && fifo_count == ($clog2(DEPTH)+1)'(DEPTH) && !pop_pend)
      |=> ovf_flag); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !srst_active && !(reg_wr && reg_addr == OFF_LEVEL && reg_wdata[LVL_OVF]))
      |=> ovf_flag); // R3

  AST_POP_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    pop_pend |=> (!pop_pend || $past(reg_wr && reg_addr == OFF_CTRL && reg_wdata[CTRL_POP]))); // R4

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_pend && fifo_empty && !evt_any) |=> fifo_count == '0); // R5

  AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_pend && !fifo_empty && evt_any && !srst_active) |=> $stable(fifo_count)); // R5

  AST_HEAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == OFF_ADDR || reg_addr == OFF_STAT) && fifo_empty)
      |=> reg_rdata == '0); // R6

  AST_SRST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 16'(SRST_CYCLES)); // R7

  AST_SRST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_active) |-> run_len == 16'(SRST_CYCLES)); // R7

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_active |=> (fifo_count == '0 && !ovf_flag && parity_out == '0)); // R7

  AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_CTRL) |=> reg_rdata[31:3] == '0); // R9
endmodule

bind ecc_err_log ecc_log_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .SRST_CYCLES(SRST_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_valid   (evt_valid),
  .evt_corr    (evt_corr),
  .evt_unc     (evt_unc),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .parity_out  (parity_out),
  .srst_active (srst_active),
  .pop_pend    (pop_pend),
  .ovf_flag    (ovf_flag),
  .fifo_empty  (fifo_empty),
  .fifo_count  (fifo_count)
);

// File: tb/ecc_err_log_test.sv
`timescale 1ns/1ps
module ecc_err_log_test;
  localparam int ADDR_W = 26;
  localparam int DEPTH  = 8;
  localparam int SRST   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              evt_valid = 1'b0;
  logic [ADDR_W-1:0] evt_addr = '0;
  logic              evt_corr = 1'b0;
  logic              evt_unc = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [4:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              bypass_en;
  logic [7:0]        parity_out;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic [31:0] d;

  always #2 clk = ~clk;

  ecc_err_log #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SRST_CYCLES(SRST)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_addr(evt_addr),
    .evt_corr(evt_corr), .evt_unc(evt_unc), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bypass_en(bypass_en), .parity_out(parity_out)
  );

  function automatic logic [ADDR_W-1:0] addr_of(int i);
    return ADDR_W'(i * 40503 + 17);
  endfunction

  function automatic logic [1:0] kind_of(int i);
    return 2'((i % 3) + 1);
  endfunction

  function automatic logic [31:0] stat_of(logic [1:0] k);
    logic [31:0] s = '0;
    s[0]  = k[0];
    s[16] = k[1];
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] q);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    q = reg_rdata;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic ev(logic [ADDR_W-1:0] a, logic [1:0] k);
    evt_valid = 1'b1; evt_addr = a; evt_corr = k[0]; evt_unc = k[1];
    @(negedge clk);
    evt_valid = 1'b0; evt_corr = 1'b0; evt_unc = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset values, reserved and unmapped offsets
    chk("R9 rdata after reset", reg_rdata, 32'h0);
    chk("R9 bypass after reset", 32'(bypass_en), 32'h0);
    chk("R9 parity after reset", 32'(parity_out), 32'h0);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d);
      chk("R9 register reset/unmapped", d, 32'h0);
    end

    // R1: an event with neither flag is ignored
    ev(addr_of(99), 2'b00);
    rd(5'h00, d);
    chk("R1 flagless event ignored", d, 32'h0);

    // R2: level sweep while filling
    for (int i = 0; i < DEPTH; i++) begin
      ev(addr_of(i), kind_of(i));
      rd(5'h00, d);
      chk("R2 level while filling", d, 32'((i + 1) % DEPTH));
    end

    // R3: event on a full log is dropped, sticky flag set
    ev(addr_of(50), 2'b11);
    rd(5'h00, d);
    chk("R3 overflow set, full reads 0", d, 32'h8000_0000);
    wr(5'h00, 32'h0000_0000);
    rd(5'h00, d);
    chk("R3 writing 0 keeps flag", d, 32'h8000_0000);
    wr(5'h00, 32'h8000_0000);
    rd(5'h00, d);
    chk("R3 write-one clears flag", d, 32'h0);

    // R1/R4: drain in order
    for (int i = 0; i < DEPTH; i++) begin
      rd(5'h04, d);
      chk("R1 address head order", d, 32'(addr_of(i)));
      rd(5'h08, d);
      chk("R1 status head order", d, stat_of(kind_of(i)));
      wr(5'h0C, 32'h2);
      if (i == 0) begin
        rd(5'h0C, d);
        chk("R4 pop bit reads 1 once", d, 32'h2);
      end else begin
        @(negedge clk);
      end
      rd(5'h00, d);
      chk("R4 level after pop", d, 32'(DEPTH - 1 - i));
    end
    rd(5'h0C, d);
    chk("R4 pop bit self-clears", d, 32'h0);

    // R6: heads read zero when empty
    rd(5'h04, d);
    chk("R6 empty address head", d, 32'h0);
    rd(5'h08, d);
    chk("R6 empty status head", d, 32'h0);

    // R5: pop on empty ignored
    wr(5'h0C, 32'h2);
    rd(5'h0C, d);
    chk("R5 pop on empty bit set", d, 32'h2);
    rd(5'h0C, d);
    chk("R5 pop on empty bit clears", d, 32'h0);
    rd(5'h00, d);
    chk("R5 pop on empty level", d, 32'h0);

    // R5: pop and push in the same cycle
    ev(addr_of(20), 2'b01);
    ev(addr_of(21), 2'b10);
    wr(5'h0C, 32'h2);
    ev(addr_of(22), 2'b11);
    rd(5'h00, d);
    chk("R5 push+pop level", d, 32'h2);
    rd(5'h04, d);
    chk("R5 push+pop head", d, 32'(addr_of(21)));

    // R8: bypass and parity
    wr(5'h0C, 32'h4);
    chk("R8 bypass enabled", 32'(bypass_en), 32'h1);
    wr(5'h10, 32'h0000_01A5);
    rd(5'h10, d);
    chk("R8 parity read, reserved zero", d, 32'hA5);
    chk("R8 parity output", 32'(parity_out), 32'hA5);
    rd(5'h0C, d);
    chk("R8 control shows bypass", d, 32'h4);

    // fill to overflow again before the soft reset
    for (int i = 0; i < DEPTH - 1; i++) ev(addr_of(30 + i), kind_of(i));
    rd(5'h00, d);
    chk("R3 overflow before soft reset", d, 32'h8000_0000);

    // R7: soft reset of exactly SRST cycles
    wr(5'h0C, 32'h1);
    ev(addr_of(60), 2'b01);
    wr(5'h10, 32'h0000_0033);
    wr(5'h0C, 32'h1);
    repeat (SRST - 4) @(negedge clk);
    rd(5'h0C, d);
    chk("R7 soft reset active in last cycle", d, 32'h1);
    rd(5'h0C, d);
    chk("R7 soft reset self-clears", d, 32'h0);
    rd(5'h00, d);
    chk("R7 log and flag cleared", d, 32'h0);
    rd(5'h10, d);
    chk("R7 parity cleared", d, 32'h0);
    rd(5'h04, d);
    chk("R7 event during reset ignored", d, 32'h0);

    // R9: reserved control bits
    wr(5'h0C, 32'hFFFF_FFF8);
    rd(5'h0C, d);
    chk("R9 control reserved bits", d, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule